// File: doc/BRIEF.md
# Multichannel Serial ADC Interface

This block runs an external 12-bit serial analog-to-digital converter on behalf of a servo loop that serves up to six feedback channels, one at a time. A timing controller picks a channel on a 3-bit select and pulses a start input. The block then lowers the converter's chip select and clocks out an 8-bit command that carries the channel number. It waits for the converter's end-of-conversion strobe and clocks in the 16-bit reply. The top 12 bits are kept. The block presents the result on a parallel output, pulses a one-cycle write strobe so that the downstream error generator stores the sample, and reports ready.

The serial clock comes from the system clock through a divider. Each half period lasts `DIV_HALF` system clocks, and the default of 25 keeps the serial clock at 2 MHz from a 100 MHz system clock. If the converter never raises its strobe, a timeout of `TIMEOUT_CYC` clocks ends the attempt. The default of 1000 is about 10 µs at 100 MHz. On a timeout the block releases chip select and goes back to idle without writing, and the previous result stays on the output.

The result side is a plain strobe with no back-pressure. The error generator must take the sample in the cycle the write strobe is high, and the next sample cannot arrive before the next start is accepted.

Top module: `adc_serial_link`

## Requirements
- R1: While reset is held and right after it, chip select is high, the serial clock and command line are low, ready is high, the write strobe is low and the result is zero.
- R2: A start is accepted only when ready is high and the channel select is below 6. One clock after acceptance, ready falls and chip select falls. A start with select 6 or 7 is ignored: ready and chip select stay high and no serial clock appears.
- R3: The command is 8 bits, sent MSB first and valid at each rising serial clock edge. In order it carries a 1 (start bit), the channel select MSB first, a 1 (single-ended), a 1 (unipolar) and 11 (external-clock mode).
- R4: The serial clock idles low and every half period lasts `DIV_HALF` system clocks. The first rising edge comes `DIV_HALF` clocks after acceptance. There are 8 pulses for the command and 16 for the reply, and none while the block waits for the strobe or while chip select is high.
- R5: After the command the block sends no serial clock until the end-of-conversion strobe is high. It then reads the data-in line at each of 16 rising edges, and the result is the first 12 bits received, MSB first. The last 4 bits are discarded.
- R6: One clock after the 16th falling serial clock edge, the new result appears, the write strobe is high for exactly one clock, ready rises and chip select rises, all on the same edge. The result changes at no other time.
- R7: If the strobe is still low `TIMEOUT_CYC`+1 clocks after the 8th falling serial clock edge, chip select and ready rise at that edge, the write strobe stays low and the previous result is held.
- R8: A start that arrives while ready is low is ignored: the conversion in progress continues and writes once.
- R9: The channel is captured when the start is accepted. Changing the select during the conversion does not alter the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset from the timing controller |
| start | input | 1 | Request to begin one conversion |
| chan_sel | input | 3 | Channel to convert (0 to 5) |
| eoc | input | 1 | End-of-conversion strobe from the converter, high when data is ready |
| adc_sdi | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_sdo | output | 1 | Serial command line to the converter |
| sample | output | 12 | Latest converted result |
| wr_stb | output | 1 | One-clock write strobe toward the error generator |
| ready | output | 1 | High when idle and a result (or timeout) has been reported |

## Verification
Chip select and ready respond one clock after an accepted start, and the first rising serial clock edge follows `DIV_HALF` clocks later. The bench counts system clocks between rising edges and expects `2*DIV_HALF`. The result, write strobe and ready are due exactly one clock after the 16th falling serial edge. A timeout is due `TIMEOUT_CYC`+1 clocks after the 8th falling edge. The bench samples every output on falling system clock edges and counts those edges from the reference event. It checks that the outputs have not yet changed one edge early and that they hold the expected value on the due edge.

// File: rtl/adcl_pkg.sv
package adcl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CMD,
    PH_WAIT,
    PH_READ
  } adcl_phase_e;

  localparam int CMD_BITS = 8;
  localparam int RD_BITS  = 16;
  localparam int RES_BITS = 12;
  localparam int CH_W     = 3;

  // start bit, channel, single-ended, unipolar, external clock mode
  function automatic logic [CMD_BITS-1:0] build_cmd(input logic [CH_W-1:0] ch);
    return {1'b1, ch, 1'b1, 1'b1, 2'b11};
  endfunction

endpackage

// File: rtl/adcl_tick_gen.sv
module adcl_tick_gen #(
  parameter int DIV_HALF = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign tick = run && (cnt == LAST);

  generate
    if (DIV_HALF > 1) begin : g_gap
      // R4
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/adcl_bit_engine.sv
module adcl_bit_engine #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [CNT_W-1:0]  load_len,
  input  logic              tick,
  input  logic              sdi,
  output logic              sclk,
  output logic              sdo,
  output logic              active,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);

  logic [WORD_W-1:0] tx_q;
  logic [CNT_W-1:0]  left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_word <= '0;
      left_q  <= '0;
      active  <= 1'b0;
      sclk    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        tx_q    <= load_word;
        rx_word <= '0;
        left_q  <= load_len;
        active  <= 1'b1;
        sclk    <= 1'b0;
      end else if (active && tick) begin
        if (!sclk) begin
          sclk    <= 1'b1;
          rx_word <= {rx_word[WORD_W-2:0], sdi};
        end else begin
          sclk   <= 1'b0;
          tx_q   <= {tx_q[WORD_W-2:0], 1'b0};
          left_q <= left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end
      end
    end
  end

  assign sdo = active && tx_q[WORD_W-1];

  // R4
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(sclk));

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sclk);

endmodule

// File: rtl/adcl_ctrl.sv
module adcl_ctrl
  import adcl_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000,
  parameter int NCHAN       = 6,
  localparam int LEN_W      = $clog2(RD_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CH_W-1:0]     chan_sel,
  input  logic                eoc,
  input  logic                eng_done,
  input  logic [RD_BITS-1:0]  rx_word,
  output logic                eng_load,
  output logic [RD_BITS-1:0]  eng_word,
  output logic [LEN_W-1:0]    eng_len,
  output logic                cs_n,
  output logic                ready,
  output logic                wr_stb,
  output logic [RES_BITS-1:0] sample
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0]   TLAST    = TW'(TIMEOUT_CYC - 1);
  localparam logic [CH_W:0]   CH_LIMIT = (CH_W + 1)'(NCHAN);

  adcl_phase_e   state;
  logic [TW-1:0] wait_cnt;
  logic          accept;
  logic          eoc_go;

  assign accept = (state == PH_IDLE) && start && ({1'b0, chan_sel} < CH_LIMIT);
  assign eoc_go = (state == PH_WAIT) && eoc;

  assign eng_load = accept || eoc_go;
  assign eng_word = accept ? {build_cmd(chan_sel), {(RD_BITS - CMD_BITS){1'b0}}} : '0;
  assign eng_len  = accept ? LEN_W'(CMD_BITS) : LEN_W'(RD_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PH_IDLE;
      wait_cnt <= '0;
      cs_n     <= 1'b1;
      ready    <= 1'b1;
      wr_stb   <= 1'b0;
      sample   <= '0;
    end else begin
      wr_stb <= 1'b0;
      unique case (state)
        PH_IDLE: begin
          if (accept) begin
            state <= PH_CMD;
            cs_n  <= 1'b0;
            ready <= 1'b0;
          end
        end
        PH_CMD: begin
          if (eng_done) begin
            state    <= PH_WAIT;
            wait_cnt <= '0;
          end
        end
        PH_WAIT: begin
          if (eoc) begin
            state <= PH_READ;
          end else if (wait_cnt == TLAST) begin
            state <= PH_IDLE;
            cs_n  <= 1'b1;
            ready <= 1'b1;
          end else begin
            wait_cnt <= wait_cnt + TW'(1);
          end
        end
        PH_READ: begin
          if (eng_done) begin
            state  <= PH_IDLE;
            sample <= rx_word[RD_BITS-1 -: RES_BITS];
            wr_stb <= 1'b1;
            ready  <= 1'b1;
            cs_n   <= 1'b1;
          end
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  // R6
  wr_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (ready && cs_n));

  // R6
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R2
  bad_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && start && ({1'b0, chan_sel} >= CH_LIMIT)) |=> (ready && cs_n));

  // R7
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_WAIT) |-> (wait_cnt <= TLAST));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PH_CMD) && !eng_done) |=> (state == PH_CMD || state == PH_WAIT));

endmodule

// File: rtl/adc_serial_link.sv
module adc_serial_link
  import adcl_pkg::*;
#(
  parameter int DIV_HALF    = 25,
  parameter int TIMEOUT_CYC = 1000,
  parameter int NCHAN       = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CH_W-1:0]     chan_sel,
  input  logic                eoc,
  input  logic                adc_sdi,
  output logic                adc_cs_n,
  output logic                adc_sclk,
  output logic                adc_sdo,
  output logic [RES_BITS-1:0] sample,
  output logic                wr_stb,
  output logic                ready
);

  localparam int LEN_W = $clog2(RD_BITS + 1);

  logic               tick;
  logic               eng_active;
  logic               eng_done;
  logic               eng_load;
  logic [RD_BITS-1:0] eng_word;
  logic [LEN_W-1:0]   eng_len;
  logic [RD_BITS-1:0] rx_word;

  adcl_tick_gen #(.DIV_HALF(DIV_HALF)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (eng_active),
    .tick  (tick)
  );

  adcl_bit_engine #(.WORD_W(RD_BITS)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (eng_load),
    .load_word (eng_word),
    .load_len  (eng_len),
    .tick      (tick),
    .sdi       (adc_sdi),
    .sclk      (adc_sclk),
    .sdo       (adc_sdo),
    .active    (eng_active),
    .done      (eng_done),
    .rx_word   (rx_word)
  );

  adcl_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC), .NCHAN(NCHAN)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .chan_sel (chan_sel),
    .eoc      (eoc),
    .eng_done (eng_done),
    .rx_word  (rx_word),
    .eng_load (eng_load),
    .eng_word (eng_word),
    .eng_len  (eng_len),
    .cs_n     (adc_cs_n),
    .ready    (ready),
    .wr_stb   (wr_stb),
    .sample   (sample)
  );

  // R4
  cs_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);

  // R7
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> $stable(sample));

endmodule

// File: tb/test_adc_serial_link.sv
module test_adc_serial_link;

  localparam int DIV = 3;
  localparam int TMO = 120;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  chan_sel = 3'd0;
  logic        eoc = 1'b0;
  logic        sdi = 1'b0;
  logic        cs_n, sclk, sdo, wr_stb, ready;
  logic [11:0] sample;

  int checks = 0;
  int fails = 0;
  int wr_seen = 0;
  bit done_flag = 1'b0;

  adc_serial_link #(.DIV_HALF(DIV), .TIMEOUT_CYC(TMO)) i_adc_serial_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .chan_sel (chan_sel),
    .eoc      (eoc),
    .adc_sdi  (sdi),
    .adc_cs_n (cs_n),
    .adc_sclk (sclk),
    .adc_sdo  (sdo),
    .sample   (sample),
    .wr_stb   (wr_stb),
    .ready    (ready)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (wr_stb) wr_seen++;

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic pulse_start(input logic [2:0] ch);
    @(negedge clk);
    chan_sel = ch;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Capture the 8 command bits at rising SCLK; report first-rise delay and rise spacing.
  task automatic capture_cmd(output logic [7:0] cmd, output int first, output int gap);
    int ncyc = 0;
    int rises = 0;
    logic prev = 1'b0;
    cmd = '0;
    first = 0;
    gap = 0;
    while (rises < 8 && ncyc < 2000) begin
      @(negedge clk);
      ncyc++;
      if (sclk && !prev) begin
        rises++;
        cmd = {cmd[6:0], sdo};
        if (rises == 1) first = ncyc;
        if (rises == 2) gap = ncyc - first;
      end
      prev = sclk;
    end
    while (sclk) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R1 cs_n in reset", int'(cs_n), 1);
    chk_eq("R1 sclk in reset", int'(sclk), 0);
    chk_eq("R1 ready in reset", int'(ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 sdo after reset", int'(sdo), 0);
    chk_eq("R1 wr_stb after reset", int'(wr_stb), 0);
    chk_eq("R1 sample after reset", int'(sample), 0);
  endtask

  task automatic t_convert(input logic [2:0] ch, input logic [11:0] val,
                           input bit scramble, input bit poke);
    logic [7:0]  cmd;
    logic [15:0] w16;
    int first, gap, w0, sclk_hi;
    w16 = {val, 4'b0000};
    w0 = wr_seen;
    pulse_start(ch);
    chk_eq("R2 ready low after accept", int'(ready), 0);
    chk_eq("R2 cs_n low after accept", int'(cs_n), 0);
    if (scramble) chan_sel = ~ch;
    capture_cmd(cmd, first, gap);
    chk_eq(scramble ? "R9 command keeps captured channel" : "R3 command word",
           int'(cmd), int'({1'b1, ch, 4'b1111}));
    chk_eq("R4 first rising edge delay", first, DIV);
    chk_eq("R4 rising edge spacing", gap, 2 * DIV);
    sclk_hi = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (sclk) sclk_hi++;
    end
    if (poke) begin
      chan_sel = 3'd4;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk_eq("R8 ready stays low on busy start", int'(ready), 0);
      chk_eq("R8 cs_n stays low on busy start", int'(cs_n), 0);
      repeat (3) begin
        @(negedge clk);
        if (sclk) sclk_hi++;
      end
    end
    chk_eq("R5 no sclk before eoc", sclk_hi, 0);
    sdi = w16[15];
    eoc = 1'b1;
    for (int k = 14; k >= 0; k--) begin
      @(negedge sclk);
      sdi = w16[k];
    end
    @(negedge sclk);
    @(negedge clk);
    chk_eq("R6 ready not early", int'(ready), 0);
    @(negedge clk);
    chk_eq("R6 ready on due edge", int'(ready), 1);
    chk_eq("R6 wr_stb on due edge", int'(wr_stb), 1);
    chk_eq("R6 cs_n on due edge", int'(cs_n), 1);
    chk_eq("R5 result value", int'(sample), int'(val));
    @(negedge clk);
    chk_eq("R6 wr_stb one cycle", int'(wr_stb), 0);
    chk_eq(poke ? "R8 single write" : "R6 single write", wr_seen - w0, 1);
    eoc = 1'b0;
    sdi = 1'b0;
  endtask

  task automatic t_bad_chan(input logic [2:0] ch);
    int w0, hi;
    w0 = wr_seen;
    hi = 0;
    pulse_start(ch);
    for (int i = 0; i < 3 * DIV; i++) begin
      @(negedge clk);
      if (sclk || !cs_n || !ready) hi++;
    end
    chk_eq("R2 invalid channel ignored", hi, 0);
    chk_eq("R2 invalid channel no write", wr_seen - w0, 0);
  endtask

  task automatic t_timeout(input logic [2:0] ch, input logic [11:0] held);
    logic [7:0] cmd;
    int first, gap, w0, n, hi;
    w0 = wr_seen;
    pulse_start(ch);
    capture_cmd(cmd, first, gap);
    chk_eq("R3 command before timeout", int'(cmd), int'({1'b1, ch, 4'b1111}));
    n = 0;
    hi = 0;
    while (!ready && n < 4 * TMO) begin
      @(negedge clk);
      n++;
      if (sclk) hi++;
    end
    chk_eq("R7 timeout cycle count", n, TMO + 1);
    chk_eq("R7 cs_n high after timeout", int'(cs_n), 1);
    chk_eq("R7 no write on timeout", wr_seen - w0, 0);
    chk_eq("R7 result held", int'(sample), int'(held));
    chk_eq("R4 no sclk while waiting", hi, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    t_reset();
    t_convert(3'd0, 12'hA5C, 1'b0, 1'b0);
    t_convert(3'd5, 12'hFFF, 1'b0, 1'b0);
    t_convert(3'd3, 12'h000, 1'b1, 1'b0);
    t_convert(3'd2, 12'h801, 1'b0, 1'b1);
    t_bad_chan(3'd6);
    t_bad_chan(3'd7);
    t_timeout(3'd1, 12'h801);
    t_convert(3'd4, 12'h3C3, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    finish_up();
  end

endmodule